// File: doc/BRIEF.md
# Two-Rate I2C Clock Timing Generator

This block drives the clock line of an I2C master. A functional clock is first divided by a programmable prescaler to form a slower module clock. Two packed count words then set how long the clock line stays low and how long it stays high. Each count word holds two timing sets. The low byte holds the fast/standard value and the high byte holds the high-speed value. The phase lengths are the programmed value plus a fixed offset of six counting ticks.

A high-speed transfer has two parts. The first part sends the master code, and it always uses the fast/standard bytes through the prescaler. When the surrounding controller raises the switch request, the generator moves to the high-speed bytes at the start of the next low phase. From then on it counts on the undivided functional clock, and it stays on that set until it returns to idle. The high phase only starts counting once the sensed line is actually high, so a slave can stretch the clock by holding the line low.

The prescaler, the count words and the high-speed mode flag are captured only at the moment a run starts from idle. Writes made during a run therefore cannot disturb the waveform. Dropping the run request lets the current phase finish and then parks the line released (high). Clearing the enable parks the line released at once.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, the block is idle from the next clock edge on, with `scl_o` = 1 (released) and `busy` = 0, whatever `run` is.
- R2: After reset, and while idle with `run` low, `scl_o` = 1 and `busy` = 0, even while the configuration inputs change.
- R3: When `run` is sampled high in idle with `enable` high, `scl_o` goes low after that edge. In fast/standard timing, the low phase lasts (low_cfg[7:0] + 6) × (psc_cfg + 1) clock cycles.
- R4: In fast/standard timing, the high phase lasts (high_cfg[7:0] + 6) × (psc_cfg + 1) clock cycles. The count starts with the first cycle in which `scl_in` is seen high.
- R5: After releasing the line, the block keeps `scl_o` = 1 and does not count for as long as `scl_in` stays low (clock stretching).
- R6: With `hs_mode` captured high, once `hs_switch` is sampled high at the end of a high phase, every later low phase lasts low_cfg[15:8] + 6 cycles and every later high phase lasts high_cfg[15:8] + 6 cycles. These counts run on the undivided clock.
- R7: With `hs_mode` captured low, `hs_switch` has no effect, and all phases keep the fast/standard timing.
- R8: Changes to `psc_cfg`, `low_cfg`, `high_cfg` and `hs_mode` during a run take effect only at the next start from idle.
- R9: If `run` is low when a phase ends, the block goes idle with `scl_o` = 1. A low phase in progress still runs to its full length.
- R10: Every run starts in fast/standard timing, even when `hs_switch` is already high, and the high-speed selection is cleared on return to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; low forces idle with the line released |
| run | input | 1 | Request to keep generating clock pulses |
| hs_mode | input | 1 | Transfer is high-speed (captured at start) |
| hs_switch | input | 1 | Request to move to the high-speed timing set |
| psc_cfg | input | PSC_W | Prescaler; divides by psc_cfg + 1 |
| low_cfg | input | 2*CNT_W | Low-phase counts: [CNT_W-1:0] fast/standard, upper byte high-speed |
| high_cfg | input | 2*CNT_W | High-phase counts: same packing as low_cfg |
| scl_in | input | 1 | Sensed clock line level (synchronous) |
| scl_o | output | 1 | Clock drive: 0 pulls low, 1 releases |
| busy | output | 1 | High while a run is in progress |

## Verification
The bound checker watches several properties on every cycle. It checks that a disabled block is released and idle, and that a run start drives the line low on the next edge. It checks that a held-low line freezes the generator in its released wait state, that the captured configuration never moves while busy, and that the high-speed selection only exists under a captured high-speed mode and never at the start of a run. The exact phase lengths can only be shown by the bench's scenarios. These include the prescaler arithmetic, the byte selection before and after the switch, the count start after a stretch, and a final low phase that completes in full before idle. The bench measures these lengths over a sweep of prescaler and count values.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Generator phases; the line is pulled low only in ST_LOW.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOW     = 2'd1,
    ST_WAIT_HI = 2'd2,
    ST_HIGH    = 2'd3
  } scl_state_e;

  // Fixed number of extra module-clock ticks added to every phase.
  localparam int unsigned SCL_PHASE_PAD = 6;

  // Number of timing sets packed in each count word.
  localparam int unsigned SCL_NUM_SETS = 2;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             bypass,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);

  logic [PSC_W-1:0] cnt_q;

  // One tick every (div + 1) active cycles, or every active cycle when bypassed.
  assign tick = active && (bypass || (cnt_q == div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (active) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int unsigned PC_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] load_val,
  input  logic            tick,
  output logic            done
);

  logic [PC_W-1:0] rem_q;

  // The phase ends on the tick that finds the remaining count at zero.
  assign done = tick && (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
    end else if (tick && (rem_q != '0)) begin
      rem_q <= rem_q - 1'b1;
    end
  end

endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [PSC_W-1:0]   psc_in,
  input  logic [2*CNT_W-1:0] low_in,
  input  logic [2*CNT_W-1:0] high_in,
  input  logic               hs_mode_in,
  output logic [PSC_W-1:0]   psc_q,
  output logic               hs_mode_q,
  output logic [CNT_W-1:0]   lo_fs,
  output logic [CNT_W-1:0]   lo_hs,
  output logic [CNT_W-1:0]   hi_fs,
  output logic [CNT_W-1:0]   hi_hs
);

  localparam int unsigned WORD_W = SCL_NUM_SETS * CNT_W;

  logic [WORD_W-1:0] word_raw [2];
  logic [WORD_W-1:0] word_q   [2];

  assign word_raw[0] = low_in;
  assign word_raw[1] = high_in;

  // One capture register per count word (0 = low phase, 1 = high phase).
  for (genvar g = 0; g < 2; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q[g] <= '0;
      else if (capture) word_q[g] <= word_raw[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q     <= '0;
      hs_mode_q <= 1'b0;
    end else if (capture) begin
      psc_q     <= psc_in;
      hs_mode_q <= hs_mode_in;
    end
  end

  // Lower field: fast/standard set; upper field: high-speed set.
  assign lo_fs = word_q[0][CNT_W-1:0];
  assign lo_hs = word_q[0][WORD_W-1:CNT_W];
  assign hi_fs = word_q[1][CNT_W-1:0];
  assign hi_hs = word_q[1][WORD_W-1:CNT_W];

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               run,
  input  logic               hs_mode,
  input  logic               hs_switch,
  input  logic [PSC_W-1:0]   psc_cfg,
  input  logic [2*CNT_W-1:0] low_cfg,
  input  logic [2*CNT_W-1:0] high_cfg,
  input  logic               scl_in,
  output logic               scl_o,
  output logic               busy
);

  localparam int unsigned PC_W = $clog2((2 ** CNT_W) + SCL_PHASE_PAD);
  localparam logic [PC_W-1:0] LOAD_ADD = PC_W'(SCL_PHASE_PAD - 1);

  scl_state_e       state;
  logic             use_hs;
  logic             hs_next;
  logic             capture;
  logic             count_en;
  logic             tick;
  logic             done;
  logic             phase_load;
  logic [PC_W-1:0]  load_val;

  logic [PSC_W-1:0] psc_q;
  logic             hs_mode_q;
  logic [CNT_W-1:0] lo_fs, lo_hs, hi_fs, hi_hs;

  assign capture  = (state == ST_IDLE) && enable && run;
  assign hs_next  = use_hs || (hs_mode_q && hs_switch);
  assign count_en = (state == ST_LOW) || (state == ST_HIGH) ||
                    ((state == ST_WAIT_HI) && scl_in);

  assign phase_load = capture ||
                      (enable && run && done &&
                       ((state == ST_LOW) || (state == ST_HIGH)));

  // Reload value: (count + 6) ticks means a terminal index of count + 5.
  always_comb begin
    if (capture) begin
      load_val = PC_W'(low_cfg[CNT_W-1:0]) + LOAD_ADD;
    end else if (state == ST_LOW) begin
      load_val = PC_W'(use_hs ? hi_hs : hi_fs) + LOAD_ADD;
    end else begin
      load_val = PC_W'(hs_next ? lo_hs : lo_fs) + LOAD_ADD;
    end
  end

  scl_cfg_latch #(
    .PSC_W (PSC_W),
    .CNT_W (CNT_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .psc_in     (psc_cfg),
    .low_in     (low_cfg),
    .high_in    (high_cfg),
    .hs_mode_in (hs_mode),
    .psc_q      (psc_q),
    .hs_mode_q  (hs_mode_q),
    .lo_fs      (lo_fs),
    .lo_hs      (lo_hs),
    .hi_fs      (hi_fs),
    .hi_hs      (hi_hs)
  );

  scl_prescaler #(
    .PSC_W (PSC_W)
  ) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (phase_load),
    .active (count_en),
    .bypass (use_hs),
    .div    (psc_q),
    .tick   (tick)
  );

  scl_phase_counter #(
    .PC_W (PC_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (load_val),
    .tick     (tick),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      use_hs <= 1'b0;
    end else if (!enable) begin
      state  <= ST_IDLE;
      use_hs <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          use_hs <= 1'b0;
          if (run) state <= ST_LOW;
        end
        ST_LOW: begin
          if (done) state <= run ? ST_WAIT_HI : ST_IDLE;
        end
        ST_WAIT_HI: begin
          if (scl_in) state <= ST_HIGH;
        end
        ST_HIGH: begin
          if (done) begin
            if (run) begin
              state  <= ST_LOW;
              use_hs <= hs_next;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scl_o = (state != ST_LOW);
  assign busy  = (state != ST_IDLE);

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             run,
  input logic             scl_in,
  input logic             scl_o,
  input logic             busy,
  input scl_state_e       state,
  input logic             use_hs,
  input logic             hs_mode_q,
  input logic [PSC_W-1:0] psc_q,
  input logic [CNT_W-1:0] lo_fs,
  input logic [CNT_W-1:0] lo_hs,
  input logic [CNT_W-1:0] hi_fs,
  input logic [CNT_W-1:0] hi_hs
);

  // R1: disabled means released and idle on the next edge
  p_disabled_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !busy));

  // R3: a start from idle pulls the line low on the next edge
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && enable && run) |=> (!scl_o && busy));

  // R5: a held-low line keeps the generator released and waiting
  p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_HI && !scl_in && enable) |=> (scl_o && state == ST_WAIT_HI));

  // R8: captured configuration is frozen during a run
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(psc_q) && $stable(lo_fs) && $stable(lo_hs) &&
                               $stable(hi_fs) && $stable(hi_hs) && $stable(hs_mode_q)));

  // R7: high-speed selection only under a captured high-speed mode
  p_hs_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    use_hs |-> hs_mode_q);

  // R10: every run begins on the fast/standard set
  p_fs_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !use_hs);

endmodule

bind scl_timing_gen scl_timing_gen_chk #(
  .PSC_W (PSC_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .run       (run),
  .scl_in    (scl_in),
  .scl_o     (scl_o),
  .busy      (busy),
  .state     (state),
  .use_hs    (use_hs),
  .hs_mode_q (hs_mode_q),
  .psc_q     (psc_q),
  .lo_fs     (lo_fs),
  .lo_hs     (lo_hs),
  .hi_fs     (hi_fs),
  .hi_hs     (hi_hs)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

  localparam int PSC_W = 8;
  localparam int CNT_W = 8;
  localparam int PAD   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic run = 1'b0;
  logic hs_mode = 1'b0;
  logic hs_switch = 1'b0;
  logic stretch = 1'b0;
  logic [PSC_W-1:0]   psc_cfg = '0;
  logic [2*CNT_W-1:0] low_cfg = '0;
  logic [2*CNT_W-1:0] high_cfg = '0;
  wire scl_in;
  wire scl_o;
  wire busy;

  // Wired-AND line: a slave stretches by pulling low.
  assign scl_in = scl_o & ~stretch;

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  scl_timing_gen #(.PSC_W(PSC_W), .CNT_W(CNT_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .run       (run),
    .hs_mode   (hs_mode),
    .hs_switch (hs_switch),
    .psc_cfg   (psc_cfg),
    .low_cfg   (low_cfg),
    .high_cfg  (high_cfg),
    .scl_in    (scl_in),
    .scl_o     (scl_o),
    .busy      (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic meas_low(output int n);
    n = 0;
    while (!scl_o && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic meas_high(input int s, output int n, output bit held);
    held = 1'b1;
    for (int i = 0; i < s; i++) begin
      stretch = 1'b1;
      if (!scl_o || !busy) held = 1'b0;
      @(negedge clk);
    end
    stretch = 1'b0;
    n = 0;
    while (scl_o && busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start_run();
    run = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_and_check_idle(input int exp_low, input string req);
    int n;
    run = 1'b0;
    meas_low(n);
    check(n == exp_low, req, n, exp_low);
    check(scl_o && !busy, "R9 idle after stop", {30'd0, scl_o, busy}, 2);
    repeat (3) @(negedge clk);
    check(scl_o && !busy, "R9 stays idle", {30'd0, scl_o, busy}, 2);
  endtask

  task automatic fs_case(input int p, input int lo, input int hi, input int s);
    int n;
    int e_lo;
    int e_hi;
    bit held;
    psc_cfg  = PSC_W'(p);
    low_cfg  = {8'd3, 8'(lo)};
    high_cfg = {8'd9, 8'(hi)};
    hs_mode  = 1'b0;
    e_lo = (lo + PAD) * (p + 1);
    e_hi = (hi + PAD) * (p + 1);
    start_run();
    meas_low(n);
    check(n == e_lo, "R3 low phase", n, e_lo);
    meas_high(s, n, held);
    check(n == e_hi, "R4 high phase", n, e_hi);
    if (s > 0) check(held, "R5 stretch hold", int'(held), 1);
    stop_and_check_idle(e_lo, "R9 final low full length");
    wait_idle();
  endtask

  task automatic main_seq();
    int n;
    bit held;
    // Reset state
    repeat (3) @(negedge clk);
    check(scl_o && !busy, "R2 reset state", {30'd0, scl_o, busy}, 2);
    rst_n = 1'b1;
    enable = 1'b1;
    // R2: idle with run low while the configuration moves
    for (int i = 0; i < 20; i++) begin
      psc_cfg = PSC_W'(i);
      low_cfg = 16'(i * 37);
      @(negedge clk);
      if (!(scl_o && !busy)) check(1'b0, "R2 idle released", {30'd0, scl_o, busy}, 2);
    end
    check(scl_o && !busy, "R2 idle released", {30'd0, scl_o, busy}, 2);

    // Sweep of fast/standard timing (R3, R4, R5, R9)
    for (int p = 0; p < 4; p++) begin
      for (int li = 0; li < 3; li++) begin
        for (int hi = 0; hi < 2; hi++) begin
          fs_case(p, (li == 0) ? 0 : ((li == 1) ? 1 : 7), hi * 3, (p + li) % 3);
        end
      end
    end

    // R6 / R10: high-speed run, switch already requested at start
    psc_cfg   = 8'd2;
    low_cfg   = {8'd4, 8'd1};
    high_cfg  = {8'd2, 8'd3};
    hs_mode   = 1'b1;
    hs_switch = 1'b1;
    start_run();
    meas_low(n);
    check(n == 21, "R10 first low uses fast set", n, 21);
    meas_high(0, n, held);
    check(n == 27, "R10 first high uses fast set", n, 27);
    meas_low(n);
    check(n == 10, "R6 high-speed low", n, 10);
    meas_high(3, n, held);
    check(n == 8, "R6 high-speed high after stretch", n, 8);
    check(held, "R5 stretch hold in high-speed", int'(held), 1);
    stop_and_check_idle(10, "R6 high-speed final low");
    wait_idle();

    // R10: selection cleared at idle; new run starts on the fast set
    hs_switch = 1'b0;
    start_run();
    meas_low(n);
    check(n == 21, "R10 restart uses fast set", n, 21);
    meas_high(0, n, held);
    check(n == 27, "R10 restart high fast set", n, 27);
    stop_and_check_idle(21, "R10 no switch keeps fast low");
    wait_idle();

    // R7: switch request ignored without high-speed mode
    hs_mode   = 1'b0;
    hs_switch = 1'b1;
    start_run();
    meas_low(n);
    check(n == 21, "R7 first low", n, 21);
    meas_high(0, n, held);
    check(n == 27, "R7 high stays fast", n, 27);
    meas_low(n);
    check(n == 21, "R7 second low stays fast", n, 21);
    meas_high(0, n, held);
    check(n == 27, "R7 second high stays fast", n, 27);
    stop_and_check_idle(21, "R7 final low fast");
    hs_switch = 1'b0;
    wait_idle();

    // R8: configuration writes during a run are ignored until next start
    psc_cfg  = 8'd1;
    low_cfg  = {8'd0, 8'd2};
    high_cfg = {8'd0, 8'd1};
    start_run();
    psc_cfg  = 8'd5;
    low_cfg  = {8'd0, 8'd20};
    high_cfg = {8'd0, 8'd10};
    hs_mode  = 1'b1;
    hs_switch = 1'b1;
    meas_low(n);
    check(n == 16, "R8 low keeps captured values", n, 16);
    meas_high(0, n, held);
    check(n == 14, "R8 high keeps captured values", n, 14);
    meas_low(n);
    check(n == 16, "R8 second low keeps captured values", n, 16);
    meas_high(0, n, held);
    stop_and_check_idle(16, "R8 final low captured values");
    wait_idle();
    hs_mode = 1'b0;
    hs_switch = 1'b0;
    start_run();
    meas_low(n);
    check(n == 156, "R8 new values after idle", n, 156);
    run = 1'b0;
    wait_idle();

    // R1: disable during a low phase releases at once, run ignored
    psc_cfg = 8'd3;
    low_cfg = {8'd0, 8'd10};
    start_run();
    repeat (5) @(negedge clk);
    check(!scl_o, "R1 precondition low", int'(scl_o), 0);
    enable = 1'b0;
    @(negedge clk);
    check(scl_o && !busy, "R1 disable releases", {30'd0, scl_o, busy}, 2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!(scl_o && !busy)) check(1'b0, "R1 disabled stays idle", {30'd0, scl_o, busy}, 2);
    end
    check(scl_o && !busy, "R1 disabled stays idle", {30'd0, scl_o, busy}, 2);
    run = 1'b0;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_o && !busy, "R2 idle after re-enable", {30'd0, scl_o, busy}, 2);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule